// File: doc/BRIEF.md
# Timer Compare Output Waveform Unit

This block turns a running 16-bit timer count into two output waveforms, one per compare channel (A and B). A small control register, written through a simple write port, holds a 2-bit action field for each channel plus the two lower waveform-mode bits. The two upper waveform-mode bits arrive on a separate input. Together they select one of three operating classes: plain counting, clear-on-compare counting, or single-slope (fast) PWM. The other mode codes are accepted, but they leave the outputs frozen.

In the two non-PWM classes, a channel reacts only to a compare match. It flips, drives low or drives high. In fast PWM, each action field pairs one action at compare match with the opposite action at the counter's wrap to zero. This produces non-inverted or inverted pulse trains. A flip-on-match option exists only for channel A, and only when the top mode bit is set. When a channel's compare value equals TOP, its match action is dropped so that the duty cycle can reach its extremes.

The timer itself lives outside the block. The block samples count, TOP and the compare values on each timer tick and keeps the waveforms in registers. It also reports, per channel, whether the waveform should take over the pin.

Top module: `cmp_wave_unit`

## Requirements
- R1: After synchronous reset, the control readback is 0x00, and both waveforms and both pin-override flags are 0.
- R2: Control register layout: bits 7:6 are the channel A action field, bits 5:4 the channel B action field and bits 1:0 the low mode bits. Bits 3:2 ignore writes and read as 0.
- R3: A channel's pin-override flag is 1 when its action field is nonzero and 0 for field 00. The exception is fast PWM with field 01, where A is enabled only when the top mode bit is 1 and B is never enabled. The flag is registered and follows the control register and the upper mode bits one clock later.
- R4: In the non-PWM classes, a compare match (count equal to the compare value) on a tick acts according to the field: 01 flips the waveform, 10 drives it to 0 and 11 drives it to 1.
- R5: Fast PWM, field 10: the waveform goes to 0 on a compare match and to 1 at BOTTOM.
- R6: Fast PWM, field 11: the waveform goes to 1 on a compare match and to 0 at BOTTOM.
- R7: Fast PWM, field 01: channel A flips on a compare match when the top mode bit is 1 and otherwise holds. Channel B always holds.
- R8: Fast PWM with field 1x and a compare value equal to TOP: the match action is skipped, but the BOTTOM action still happens.
- R9: A waveform changes only on a clock where the tick input is 1. Field 00 leaves it unchanged.
- R10: BOTTOM is a tick with count 0 whose previous tick saw count equal to TOP. A count of 0 reached any other way is not BOTTOM.
- R11: In fast PWM, when a compare match and BOTTOM fall on the same tick, the match action wins.
- R12: Mode decoding uses the 4-bit mode {upper input, lower register bits}. Code 0 is normal, codes 4 and 12 are clear-on-compare, and codes 5, 6, 7, 14 and 15 are fast PWM. Every other code leaves the waveforms unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock enable; events are sampled only when high |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register readback |
| wgm_hi | input | 2 | Upper two waveform-mode bits |
| count | input | 16 | Current timer count |
| top_val | input | 16 | Current TOP value |
| cmp_a | input | 16 | Channel A compare value |
| cmp_b | input | 16 | Channel B compare value |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| pin_en_a | output | 1 | Channel A pin-override flag |
| pin_en_b | output | 1 | Channel B pin-override flag |

## Verification
A waveform is due at the first rising edge on which tick is high with the triggering count applied. It is therefore visible one clock after the inputs are presented. A pin-override flag lags by two edges after a write strobe: one edge loads the register and the next edge loads the flag. It lags by one edge after a change of the upper mode bits. The bench drives every input on falling edges and reads results on the falling edge after the relevant rising edge. For a write, it waits one extra falling edge before checking the override flags. The BOTTOM-qualification flag depends on the previous tick, so each scenario begins from reset and drives an explicit count sequence.

// File: rtl/cwu_pkg.sv
package cwu_pkg;

  typedef enum logic [1:0] {
    WC_NORMAL = 2'd0,
    WC_CTC    = 2'd1,
    WC_FAST   = 2'd2,
    WC_OTHER  = 2'd3
  } wave_class_e;

  typedef enum logic [1:0] {
    ACT_OFF  = 2'b00,
    ACT_FLIP = 2'b01,
    ACT_LOW  = 2'b10,
    ACT_HIGH = 2'b11
  } act_field_e;

  function automatic wave_class_e classify(input logic [3:0] wgm);
    case (wgm)
      4'd0:                              return WC_NORMAL;
      4'd4, 4'd12:                       return WC_CTC;
      4'd5, 4'd6, 4'd7, 4'd14, 4'd15:    return WC_FAST;
      default:                           return WC_OTHER;
    endcase
  endfunction

endpackage

// File: rtl/cwu_ctl_reg.sv
module cwu_ctl_reg
  import cwu_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output act_field_e       act_a,
  output act_field_e       act_b,
  output logic [1:0]       wgm_lo
);
  localparam int A_LSB  = REG_W - 2;
  localparam int B_LSB  = REG_W - 4;
  localparam int WG_LSB = 0;

  logic [1:0] a_q, b_q, wg_q;
  logic       rsvd_unused;

  assign rsvd_unused = ^wdata[B_LSB-1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q  <= '0;
      b_q  <= '0;
      wg_q <= '0;
    end else if (we) begin
      a_q  <= wdata[A_LSB+:2];
      b_q  <= wdata[B_LSB+:2];
      wg_q <= wdata[WG_LSB+:2];
    end
  end

  always_comb begin
    rdata             = '0;
    rdata[A_LSB+:2]   = a_q;
    rdata[B_LSB+:2]   = b_q;
    rdata[WG_LSB+:2]  = wg_q;
  end

  assign act_a  = act_field_e'(a_q);
  assign act_b  = act_field_e'(b_q);
  assign wgm_lo = wg_q;

  // R2: a write lands in the readback on the next clock with bits 3:2 clear
  assert_write_readback_R2: assert property (@(posedge clk) disable iff (rst)
    we |=> (rdata == ($past(wdata) & 8'hF3)));

endmodule

// File: rtl/cwu_event_det.sv
module cwu_event_det #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] top_val,
  output logic             bottom
);
  logic was_top_q;

  always_ff @(posedge clk) begin
    if (rst)       was_top_q <= 1'b0;
    else if (tick) was_top_q <= (count == top_val);
  end

  assign bottom = was_top_q && (count == '0);

  // R10: without a tick the TOP history flag holds
  assert_top_hist_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(was_top_q));

endmodule

// File: rtl/cwu_chan.sv
module cwu_chan
  import cwu_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter bit IS_A  = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  wave_class_e      wclass,
  input  logic             wgm_msb,
  input  act_field_e       act,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] cmp,
  input  logic [CNT_W-1:0] top_val,
  input  logic             bottom,
  output logic             wave,
  output logic             pin_en
);
  logic wave_q, pin_q, wave_d, pin_d;
  logic match, cmp_at_top;

  assign match      = (count == cmp);
  assign cmp_at_top = (cmp == top_val);

  always_comb begin
    wave_d = wave_q;
    pin_d  = (act != ACT_OFF);
    unique case (wclass)
      WC_NORMAL, WC_CTC: begin
        if (match) begin
          case (act)
            ACT_FLIP: wave_d = ~wave_q;
            ACT_LOW:  wave_d = 1'b0;
            ACT_HIGH: wave_d = 1'b1;
            default:  wave_d = wave_q;
          endcase
        end
      end
      WC_FAST: begin
        case (act)
          ACT_FLIP: begin
            pin_d = IS_A && wgm_msb;
            if (IS_A && wgm_msb && match) wave_d = ~wave_q;
          end
          ACT_LOW, ACT_HIGH: begin
            if (match && !cmp_at_top) wave_d = (act == ACT_HIGH);
            else if (bottom)          wave_d = (act == ACT_LOW);
          end
          default: wave_d = wave_q;
        endcase
      end
      default: wave_d = wave_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wave_q <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      pin_q <= pin_d;
      if (tick) wave_q <= wave_d;
    end
  end

  assign wave   = wave_q;
  assign pin_en = pin_q;

  // R9: no tick, no change
  assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(wave_q));

  // R9: a disconnected field never moves the waveform
  assert_off_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (tick && act == ACT_OFF) |=> $stable(wave_q));

  // R4: non-PWM set action on match
  assert_nonpwm_set_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && (wclass == WC_NORMAL || wclass == WC_CTC) && act == ACT_HIGH && match)
      |=> wave_q);

  // R8: a compare value at TOP never triggers the match action in fast PWM
  assert_top_ignore_R8: assert property (@(posedge clk) disable iff (rst)
    (tick && wclass == WC_FAST && act[1] && cmp_at_top && !bottom) |=> $stable(wave_q));

  generate
    if (!IS_A) begin : g_b_only
      // R7: channel B holds with field 01 in fast PWM
      assert_b_no_flip_R7: assert property (@(posedge clk) disable iff (rst)
        (tick && wclass == WC_FAST && act == ACT_FLIP) |=> $stable(wave_q));
    end
  endgenerate

endmodule

// File: rtl/cmp_wave_unit.sv
module cmp_wave_unit
  import cwu_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ctl_we,
  input  logic [REG_W-1:0] ctl_wdata,
  output logic [REG_W-1:0] ctl_rdata,
  input  logic [1:0]       wgm_hi,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] top_val,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  output logic             wave_a,
  output logic             wave_b,
  output logic             pin_en_a,
  output logic             pin_en_b
);
  localparam int NCH = 2;

  act_field_e       act_a, act_b;
  logic [1:0]       wgm_lo;
  logic [3:0]       wgm;
  wave_class_e      wclass;
  logic             bottom;
  act_field_e       act_arr  [NCH];
  logic [CNT_W-1:0] cmp_arr  [NCH];
  logic             wave_arr [NCH];
  logic             pin_arr  [NCH];

  cwu_ctl_reg #(.REG_W(REG_W)) ctl_i (
    .clk(clk), .rst(rst), .we(ctl_we), .wdata(ctl_wdata),
    .rdata(ctl_rdata), .act_a(act_a), .act_b(act_b), .wgm_lo(wgm_lo)
  );

  assign wgm    = {wgm_hi, wgm_lo};
  assign wclass = classify(wgm);

  cwu_event_det #(.CNT_W(CNT_W)) evt_i (
    .clk(clk), .rst(rst), .tick(tick), .count(count),
    .top_val(top_val), .bottom(bottom)
  );

  assign act_arr[0] = act_a;
  assign act_arr[1] = act_b;
  assign cmp_arr[0] = cmp_a;
  assign cmp_arr[1] = cmp_b;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      cwu_chan #(.CNT_W(CNT_W), .IS_A(g == 0)) ch_i (
        .clk(clk), .rst(rst), .tick(tick), .wclass(wclass),
        .wgm_msb(wgm[3]), .act(act_arr[g]), .count(count),
        .cmp(cmp_arr[g]), .top_val(top_val), .bottom(bottom),
        .wave(wave_arr[g]), .pin_en(pin_arr[g])
      );
    end
  endgenerate

  assign wave_a   = wave_arr[0];
  assign wave_b   = wave_arr[1];
  assign pin_en_a = pin_arr[0];
  assign pin_en_b = pin_arr[1];

  // R3: a disconnected field releases the pin one clock later
  assert_pin_off_a_R3: assert property (@(posedge clk) disable iff (rst)
    (act_a == ACT_OFF) |=> !pin_en_a);
  assert_pin_off_b_R3: assert property (@(posedge clk) disable iff (rst)
    (act_b == ACT_OFF) |=> !pin_en_b);

  // R12: unsupported mode codes freeze both waveforms
  assert_other_freeze_R12: assert property (@(posedge clk) disable iff (rst)
    (wclass == WC_OTHER) |=> ($stable(wave_a) && $stable(wave_b)));

endmodule

// File: tb/cmp_wave_unit_tb.sv
module cmp_wave_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [7:0]  ctl_rdata;
  logic [1:0]  wgm_hi = '0;
  logic [15:0] count = '0, top_val = 16'hFFFF, cmp_a = '0, cmp_b = '0;
  logic        wave_a, wave_b, pin_en_a, pin_en_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmp_wave_unit dut_i (
    .clk(clk), .rst(rst), .tick(tick), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .wgm_hi(wgm_hi), .count(count), .top_val(top_val),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .wave_a(wave_a), .wave_b(wave_b),
    .pin_en_a(pin_en_a), .pin_en_b(pin_en_b)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tick = 1'b0; ctl_we = 1'b0; wgm_hi = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [7:0] ctl(input logic [1:0] fa, input logic [1:0] fb,
                                     input logic [1:0] lo);
    return {fa, fb, 2'b00, lo};
  endfunction

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic step(input logic [15:0] c);
    @(negedge clk);
    count = c; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 rdata", ctl_rdata, 0);
    chk("R1 wave_a", wave_a, 0);
    chk("R1 wave_b", wave_b, 0);
    chk("R1 pin_a", pin_en_a, 0);
    chk("R1 pin_b", pin_en_b, 0);
  endtask

  task automatic t_regmap();
    do_reset();
    wr(8'hFF);
    chk("R2 rd FF", ctl_rdata, 8'hF3);
    wr(8'h9E);
    chk("R2 rd 9E", ctl_rdata, 8'h92);
    wr(ctl(2'b01, 2'b00, 2'b00));
    chk("R3 pin_a on", pin_en_a, 1);
    chk("R3 pin_b off", pin_en_b, 0);
  endtask

  task automatic t_nonpwm();
    do_reset();
    top_val = 16'hFFFF; cmp_a = 5; cmp_b = 7;
    wr(ctl(2'b01, 2'b11, 2'b00));
    step(4);  chk("R4 no match a", wave_a, 0);
    step(5);  chk("R4 flip a", wave_a, 1);
              chk("R4 b idle", wave_b, 0);
    step(7);  chk("R4 set b", wave_b, 1);
    step(5);  chk("R4 flip back a", wave_a, 0);
    wr(ctl(2'b11, 2'b10, 2'b00));
    step(5);  chk("R4 set a", wave_a, 1);
    step(7);  chk("R4 clear b", wave_b, 0);
    wr(ctl(2'b10, 2'b10, 2'b00));
    step(5);  chk("R4 clear a", wave_a, 0);
  endtask

  task automatic t_ctc();
    do_reset();
    wgm_hi = 2'b01; cmp_a = 3;
    wr(ctl(2'b11, 2'b00, 2'b00));
    step(3);  chk("R12 ctc set a", wave_a, 1);
    wr(ctl(2'b01, 2'b00, 2'b00));
    step(3);  chk("R12 ctc flip a", wave_a, 0);
    step(2);  chk("R12 ctc no match", wave_a, 0);
  endtask

  task automatic t_tick();
    do_reset();
    cmp_a = 5;
    wr(ctl(2'b01, 2'b00, 2'b00));
    @(negedge clk);
    count = 5; tick = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 no tick hold", wave_a, 0);
    wr(ctl(2'b11, 2'b00, 2'b00));
    step(5);  chk("R9 tick set", wave_a, 1);
    wr(ctl(2'b00, 2'b00, 2'b00));
    step(5);  chk("R9 field 00 hold", wave_a, 1);
    chk("R3 pin off 00", pin_en_a, 0);
  endtask

  task automatic t_fpwm();
    do_reset();
    wgm_hi = 2'b01; top_val = 9; cmp_a = 3; cmp_b = 3;
    wr(ctl(2'b10, 2'b11, 2'b11));
    step(3);  chk("R5 clr a", wave_a, 0);
              chk("R6 set b", wave_b, 1);
    for (int i = 4; i <= 9; i++) step(i[15:0]);
    chk("R5 hold a", wave_a, 0);
    chk("R6 hold b", wave_b, 1);
    step(0);  chk("R5 bottom set a", wave_a, 1);
              chk("R6 bottom clr b", wave_b, 0);
    step(3);  chk("R5 clr a again", wave_a, 0);
              chk("R6 set b again", wave_b, 1);
  endtask

  task automatic t_bottom_def();
    do_reset();
    wgm_hi = 2'b01; top_val = 9; cmp_a = 3;
    wr(ctl(2'b10, 2'b00, 2'b11));
    step(0);  chk("R10 zero w/o top", wave_a, 0);
    step(9);
    step(0);  chk("R10 zero after top", wave_a, 1);
    step(3);  chk("R10 match clr", wave_a, 0);
    step(5);
    step(0);  chk("R10 jump to zero", wave_a, 0);
  endtask

  task automatic t_fpwm01();
    do_reset();
    wgm_hi = 2'b01; top_val = 9; cmp_a = 3; cmp_b = 3;
    wr(ctl(2'b01, 2'b01, 2'b11));
    chk("R3 pin_a 01 msb0", pin_en_a, 0);
    chk("R3 pin_b 01 msb0", pin_en_b, 0);
    step(3);  chk("R7 a hold msb0", wave_a, 0);
              chk("R7 b hold msb0", wave_b, 0);
    wgm_hi = 2'b11;
    wr(ctl(2'b01, 2'b01, 2'b10));
    chk("R3 pin_a 01 msb1", pin_en_a, 1);
    chk("R3 pin_b 01 msb1", pin_en_b, 0);
    step(3);  chk("R7 a flip", wave_a, 1);
              chk("R7 b reserved", wave_b, 0);
    step(3);  chk("R7 a flip back", wave_a, 0);
    cmp_a = 9;
    step(9);  chk("R7 a flip at top", wave_a, 1);
    step(0);  chk("R7 a no bottom act", wave_a, 1);
  endtask

  task automatic t_top();
    do_reset();
    wgm_hi = 2'b11; top_val = 9; cmp_a = 9; cmp_b = 9;
    wr(ctl(2'b10, 2'b11, 2'b11));
    step(9);  chk("R8 b set ignored", wave_b, 0);
    step(0);  chk("R8 a bottom set", wave_a, 1);
              chk("R8 b bottom clr", wave_b, 0);
    step(9);  chk("R8 a clr ignored", wave_a, 1);
    step(0);  chk("R8 a stays", wave_a, 1);
    cmp_b = 5;
    step(5);  chk("R8 b set below top", wave_b, 1);
  endtask

  task automatic t_prio();
    do_reset();
    wgm_hi = 2'b01; top_val = 9; cmp_a = 0;
    wr(ctl(2'b11, 2'b00, 2'b11));
    step(9);
    step(0);  chk("R11 match beats bottom", wave_a, 1);
  endtask

  task automatic t_other();
    do_reset();
    wgm_hi = 2'b00; cmp_a = 3;
    wr(ctl(2'b11, 2'b00, 2'b01));
    step(3);  chk("R12 other mode frozen", wave_a, 0);
    chk("R3 pin in other mode", pin_en_a, 1);
  endtask

  initial begin
    t_reset();
    t_regmap();
    t_nonpwm();
    t_ctc();
    t_tick();
    t_fpwm();
    t_bottom_def();
    t_fpwm01();
    t_top();
    t_prio();
    t_other();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all R) actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule